// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block produces a line-timed interrupt for a video-game cartridge. The CPU programs it through four write targets. One target loads an 8-bit down-counter directly. One fills a reload latch. One turns interrupts on. One turns them off and also drops a pending request. The video side supplies a one-cycle strobe at the end of each scanline, the current line number, and its background and sprite rendering enables.

A strobe counts only when three things hold: interrupts are on, the line is a visible one (0 to 239), and at least one rendering enable is set. On such a strobe a non-zero counter steps down by one. A counter already at zero instead reloads from the latch and raises the interrupt request. The request is a level signal and stays high until software turns interrupts off. Only address bits 15..13 and bit 0 are decoded, so every mirror of a target address reaches that target.

Top module: `scanline_irq`

## Requirements
- R1: After reset the request output is low, interrupts are off, and both the counter and the reload latch hold zero.
- R2: A write whose address decodes to 0xC000 places the data byte in the counter. With interrupts on, a loaded value N raises the request on the (N+1)th counted strobe.
- R3: A write decoding to 0xC001 stores the data byte in the reload latch. When the counter expires it takes the latch value L, so the next request needs L+1 further counted strobes.
- R4: A write decoding to 0xE000 turns interrupts off and clears the request. A write decoding to 0xE001 turns them on and leaves the counter untouched.
- R5: A strobe on a line numbered above 239 leaves the counter unchanged.
- R6: A strobe with both rendering enables low leaves the counter unchanged. Either enable alone is enough for the strobe to count.
- R7: Once raised, the request stays high through further strobes and through writes to other targets, until a write decoding to 0xE000.
- R8: When a decoded write and a strobe fall in the same clock cycle, the write takes effect and the strobe is dropped.
- R9: While interrupts are off, strobes leave the counter unchanged.
- R10: Decoding uses the address AND 0xE001. Mirrored addresses such as 0xDFFE (load) and 0xFFFF (enable) reach their target. Writes that decode to anything else (for example 0x8000 or 0xA000) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by CPU writes and the line strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle end-of-scanline strobe |
| line_num | input | 9 | Current scanline number |
| bg_enable | input | 1 | Background rendering enabled |
| spr_enable | input | 1 | Sprite rendering enabled |
| irq_out | output | 1 | Level interrupt request |

## Verification
Each write and each strobe is registered once. The request therefore changes on the clock edge that samples the deciding strobe or the disabling write, and it is visible one cycle after the stimulus is driven. Every task drives its inputs just after a falling edge, holds them across one rising edge, and reads `irq_out` at the next falling edge. Counter values are never read directly. They are inferred from how many counted strobes pass before the request rises, checking low after each strobe before the last and high after the last.

// File: rtl/scn_irq_pkg.sv
package scn_irq_pkg;

   localparam int ADDR_W = 16;
   localparam int N_TGT  = 4;

   typedef enum logic [1:0] {
      TGT_LOAD  = 2'd0,
      TGT_LATCH = 2'd1,
      TGT_OFF   = 2'd2,
      TGT_ON    = 2'd3
   } tgt_e;

   function automatic logic [ADDR_W-1:0] tgt_addr(input int idx);
      case (idx)
         0:       tgt_addr = 16'hC000;
         1:       tgt_addr = 16'hC001;
         2:       tgt_addr = 16'hE000;
         default: tgt_addr = 16'hE001;
      endcase
   endfunction

endpackage

// File: rtl/scn_irq_decode.sv
module scn_irq_decode
   import scn_irq_pkg::*;
#(
   parameter logic [ADDR_W-1:0] DEC_MASK = 16'hE001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [N_TGT-1:0]  hit
);

   generate
      if (DEC_MASK == '0) begin : g_bad_mask
         $error("scn_irq_decode: DEC_MASK must not be zero");
      end
      for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
         localparam logic [ADDR_W-1:0] MATCH = tgt_addr(g) & DEC_MASK;
         assign hit[g] = wr_en && ((wr_addr & DEC_MASK) == MATCH);
      end
   endgenerate

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)); // R10

   AST_HIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (hit == '0)); // R10

endmodule

// File: rtl/scn_irq_qualify.sv
module scn_irq_qualify #(
   parameter int LINE_W    = 9,
   parameter int LAST_LINE = 239
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [LINE_W-1:0] line,
   input  logic              bg_on,
   input  logic              spr_on,
   input  logic              enabled,
   input  logic              wr_busy,
   output logic              fire
);

   localparam longint LINE_MAX = (64'd1 << LINE_W) - 1;

   logic visible;
   logic rendering;

   generate
      if (LINE_W < 1 || LINE_W > 16) begin : g_bad_w
         $error("scn_irq_qualify: LINE_W out of range");
      end
      if (LAST_LINE < 0) begin : g_bad_last
         $error("scn_irq_qualify: LAST_LINE must not be negative");
      end
      if (LAST_LINE >= LINE_MAX) begin : g_all_lines
         assign visible = 1'b1;
      end else begin : g_cmp_lines
         localparam logic [LINE_W-1:0] LAST_V = LINE_W'(LAST_LINE);
         assign visible = (line <= LAST_V);
      end
   endgenerate

   assign rendering = bg_on | spr_on;
   assign fire      = tick && enabled && visible && rendering && !wr_busy;

   AST_DARK_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bg_on && !spr_on) |-> !fire); // R6

   AST_OFF_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |-> !fire); // R9

endmodule

// File: rtl/scn_irq_counter.sv
module scn_irq_counter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_stb,
   input  logic              latch_stb,
   input  logic [DATA_W-1:0] din,
   input  logic              fire,
   output logic              expire
);

   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] latch_q;
   logic              at_zero;

   generate
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_w
         $error("scn_irq_counter: DATA_W out of range");
      end
   endgenerate

   assign at_zero = (cnt_q == '0);
   assign expire  = fire && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (latch_stb) begin
         latch_q <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_stb) begin
         cnt_q <= din;
      end else if (fire) begin
         if (at_zero) cnt_q <= latch_q;
         else         cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> (cnt_q == $past(din))); // R2

   AST_RELOAD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && at_zero && !load_stb) |=> (cnt_q == $past(latch_q))); // R3

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !at_zero && !load_stb) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && !load_stb) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/scanline_irq.sv
module scanline_irq
   import scn_irq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LINE_W    = 9,
   parameter int LAST_LINE = 239
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [15:0]       cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              line_tick,
   input  logic [LINE_W-1:0] line_num,
   input  logic              bg_enable,
   input  logic              spr_enable,
   output logic              irq_out
);

   logic [N_TGT-1:0] hit;
   logic             any_hit;
   logic             fire;
   logic             expire;
   logic             en_q;
   logic             irq_q;

   scn_irq_decode #(
      .DEC_MASK (16'hE001)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cpu_wr),
      .wr_addr (cpu_addr),
      .hit     (hit)
   );

   assign any_hit = |hit;

   scn_irq_qualify #(
      .LINE_W    (LINE_W),
      .LAST_LINE (LAST_LINE)
   ) u_qualify (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (line_tick),
      .line    (line_num),
      .bg_on   (bg_enable),
      .spr_on  (spr_enable),
      .enabled (en_q),
      .wr_busy (any_hit),
      .fire    (fire)
   );

   scn_irq_counter #(
      .DATA_W (DATA_W)
   ) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_stb  (hit[TGT_LOAD]),
      .latch_stb (hit[TGT_LATCH]),
      .din       (cpu_data),
      .fire      (fire),
      .expire    (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (hit[TGT_OFF]) begin
         en_q <= 1'b0;
      end else if (hit[TGT_ON]) begin
         en_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (hit[TGT_OFF]) begin
         irq_q <= 1'b0;
      end else if (expire) begin
         irq_q <= 1'b1;
      end
   end

   assign irq_out = irq_q;

   AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      hit[TGT_OFF] |=> (!irq_q && !en_q)); // R4

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !hit[TGT_OFF]) |=> irq_q); // R7

   AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(expire)); // R3

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> !fire); // R8

endmodule

// File: tb/tb_scanline_irq.sv
`timescale 1ns/1ps
module tb_scanline_irq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0] cpu_data = '0;
   logic       line_tick = 1'b0;
   logic [8:0] line_num = '0;
   logic       bg_enable = 1'b0;
   logic       spr_enable = 1'b0;
   logic       irq_out;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   scanline_irq dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_wr     (cpu_wr),
      .cpu_addr   (cpu_addr),
      .cpu_data   (cpu_data),
      .line_tick  (line_tick),
      .line_num   (line_num),
      .bg_enable  (bg_enable),
      .spr_enable (spr_enable),
      .irq_out    (irq_out)
   );

   task automatic check(input string req, input logic got, input logic exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s irq_out=%b expected=%b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic tick(input int ln, input logic bg, input logic sp);
      line_tick = 1'b1; line_num = 9'(ln); bg_enable = bg; spr_enable = sp;
      @(negedge clk);
      line_tick = 1'b0;
   endtask

   // count n strobes expecting low, then one more expecting high
   task automatic expect_after(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         tick(10, 1'b1, 1'b0);
         check(req, irq_out, 1'b0);
      end
      tick(10, 1'b1, 1'b0);
      check(req, irq_out, 1'b1);
   endtask

   task automatic t_reset;
      check("R1", irq_out, 1'b0);
      tick(0, 1'b1, 1'b1);          // disabled at reset
      check("R1", irq_out, 1'b0);
      wr(16'hE001, 8'h00);
      tick(0, 1'b1, 1'b0);          // counter zero from reset
      check("R1", irq_out, 1'b1);
      wr(16'hE000, 8'h00);
      check("R4", irq_out, 1'b0);
   endtask

   task automatic t_count;
      wr(16'hC000, 8'd3);
      wr(16'hC001, 8'd5);
      wr(16'hE001, 8'h00);
      expect_after("R2", 3);
      wr(16'hE000, 8'h00);
      check("R4", irq_out, 1'b0);
      wr(16'hE001, 8'h00);
      expect_after("R3", 5);
      wr(16'hE000, 8'h00);
   endtask

   task automatic t_level;
      wr(16'hC000, 8'd0);
      wr(16'hC001, 8'd1);
      wr(16'hE001, 8'h00);
      tick(5, 1'b1, 1'b1);
      check("R7", irq_out, 1'b1);
      for (int i = 0; i < 4; i++) begin
         tick(6, 1'b1, 1'b0);
         check("R7", irq_out, 1'b1);
      end
      wr(16'hC000, 8'd9);
      wr(16'hE001, 8'h00);
      check("R7", irq_out, 1'b1);
      wr(16'hE000, 8'h00);
      check("R7", irq_out, 1'b0);
   endtask

   task automatic t_lines;
      wr(16'hC000, 8'd1);
      wr(16'hE001, 8'h00);
      tick(240, 1'b1, 1'b1);
      tick(261, 1'b1, 1'b1);
      tick(511, 1'b1, 1'b1);
      check("R5", irq_out, 1'b0);
      tick(239, 1'b1, 1'b0);        // 1 -> 0
      check("R5", irq_out, 1'b0);
      tick(0, 1'b1, 1'b0);
      check("R5", irq_out, 1'b1);
      wr(16'hE000, 8'h00);
   endtask

   task automatic t_render;
      wr(16'hC000, 8'd1);
      wr(16'hE001, 8'h00);
      for (int i = 0; i < 3; i++) tick(20, 1'b0, 1'b0);
      check("R6", irq_out, 1'b0);
      tick(20, 1'b0, 1'b1);
      check("R6", irq_out, 1'b0);
      tick(20, 1'b1, 1'b0);
      check("R6", irq_out, 1'b1);
      wr(16'hE000, 8'h00);
   endtask

   task automatic t_disabled;
      wr(16'hC000, 8'd2);
      for (int i = 0; i < 5; i++) tick(30, 1'b1, 1'b1);
      check("R9", irq_out, 1'b0);
      wr(16'hE001, 8'h00);
      expect_after("R9", 2);
      wr(16'hE000, 8'h00);
   endtask

   task automatic t_collide;
      wr(16'hC000, 8'd1);
      wr(16'hE001, 8'h00);
      cpu_wr = 1'b1; cpu_addr = 16'hC001; cpu_data = 8'd0;
      line_tick = 1'b1; line_num = 9'd40; bg_enable = 1'b1; spr_enable = 1'b0;
      @(negedge clk);
      cpu_wr = 1'b0; line_tick = 1'b0;
      check("R8", irq_out, 1'b0);
      expect_after("R8", 1);
      wr(16'hE000, 8'h00);
   endtask

   task automatic t_mirror;
      wr(16'hDFFE, 8'd0);           // decodes to load
      wr(16'hFFFF, 8'h00);          // decodes to enable
      tick(50, 1'b1, 1'b0);
      check("R10", irq_out, 1'b1);
      wr(16'hFFFE, 8'h00);          // decodes to disable
      check("R10", irq_out, 1'b0);
      wr(16'hC000, 8'd2);
      wr(16'h8000, 8'd0);
      wr(16'hA000, 8'd0);
      wr(16'hA001, 8'd0);
      wr(16'hE001, 8'h00);
      expect_after("R10", 2);
      wr(16'hE000, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_level();
      t_lines();
      t_render();
      t_disabled();
      t_collide();
      t_mirror();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got=hung expected=done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule